// File: doc/BRIEF.md
# Receive Inactivity Timer

This block watches one UART receive channel for inactivity and reports it with two independent flags. A fixed watchdog counts bit-time ticks and raises its flag once a set number of bit times (64 by default) pass without a read of the receive FIFO. A read clears the flag and starts the count again.

The second detector is a 16-bit down-counter. In timeout mode it is reloaded from a preset each time a character is moved into the receive FIFO. When it runs out before the next character arrives, it raises a counter-ready flag. Command bytes switch timeout mode on and off. Outside timeout mode the same counter can be started and stopped by command as a plain one-shot counter. Each flag has its own interrupt gate. Baud generation and the host register file sit outside this block.

Top module: `rx_inactivity_timer`

## Requirements
- R1: After reset, `wdFlag`, `wdIrq`, `ctReady` and `ctIrq` are all low, and timeout mode is off.
- R2: With no FIFO read, `wdFlag` rises on the clock edge that samples the WD_LIMIT-th `bitTick` (default 64) counted since reset or since the last read. Cycles without `bitTick` do not advance the watchdog.
- R3: A `fifoRead` clears `wdFlag` at the next edge and restarts the bit-time count from zero.
- R4: `wdIrq` is high exactly when `wdFlag` and `wdEnable` are both high.
- R5: In timeout mode, a `charXfer` stops the counter. The next counter clock loads `reloadValue`, and the clock after that restarts the counter. `ctReady` then rises on the edge of the further max(reloadValue,1)-th counter clock, which is 2+max(reloadValue,1) counter clocks after the transfer.
- R6: The counter moves (stop, load, restart, decrement) only on cycles where `ctClkEn` is high. `ctReady` never rises on any other cycle.
- R7: Once set, `ctReady` stays high, and further counter clocks or transfers neither clear it nor flag it again. Only the arm and disarm commands clear it.
- R8: A command byte whose upper nibble is 0xA enters timeout mode, clears `ctReady`, and keeps the counter stopped until the next `charXfer`.
- R9: A command byte whose upper nibble is 0xC leaves timeout mode, clears `ctReady`, and stops the counter.
- R10: Outside timeout mode, upper nibble 0x8 loads `reloadValue` and runs the counter, so `ctReady` rises after max(reloadValue,1) counter clocks. Upper nibble 0x9 halts the counter.
- R11: Start (0x8) and stop (0x9) commands are ignored in timeout mode. `charXfer` is ignored outside timeout mode.
- R12: `ctIrq` is high exactly when `ctReady` and `ctMask` are both high.
- R13: When several events fall in the same cycle, a command takes precedence over `charXfer`, and `charXfer` takes precedence over a counter clock. The losing event has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle pulse per receive bit time |
| ctClkEn | input | 1 | Counter clock enable |
| charXfer | input | 1 | A character entered the receive FIFO |
| fifoRead | input | 1 | Receive FIFO read strobe |
| cmdValid | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command byte; the upper nibble selects the action |
| reloadValue | input | 16 | Counter preset |
| wdEnable | input | 1 | Watchdog interrupt enable |
| ctMask | input | 1 | Counter-ready interrupt mask |
| wdFlag | output | 1 | Watchdog expired |
| wdIrq | output | 1 | Gated watchdog interrupt |
| ctReady | output | 1 | Counter reached terminal count |
| ctIrq | output | 1 | Gated counter interrupt |

## Verification
Each flag is registered once after its deciding event. The watchdog flag appears at the edge that samples the last bit tick. The counter-ready flag appears at the edge of the last counted clock, which comes 2+max(reload,1) counter clocks after a transfer or max(reload,1) clocks after a start command. Both interrupt outputs follow their flag in the same cycle. The bench applies one input pattern per clock, drives it just after an edge, and samples one time unit after the following edge. It checks the expected flag value after every step, so a flag that arrives one clock early or late is caught. Idle cycles are inserted between counter clocks to confirm that nothing moves without the enable.

// File: rtl/rx_timer_pkg.sv
package rx_timer_pkg;

  localparam logic [3:0] CMD_TMO_ON  = 4'hA;
  localparam logic [3:0] CMD_TMO_OFF = 4'hC;
  localparam logic [3:0] CMD_START   = 4'h8;
  localparam logic [3:0] CMD_STOP    = 4'h9;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HALT  = 2'd1,
    PH_ARMED = 2'd2,
    PH_RUN   = 2'd3
  } ctPhase_t;

  typedef struct packed {
    logic loadCount;
    logic decCount;
    logic setReady;
    logic clrReady;
    logic wdRestart;
    logic wdAdvance;
  } tmrStrobes_t;

endpackage

// File: rtl/rx_timer_ctrl.sv
module rx_timer_ctrl
  import rx_timer_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             ctClkEn,
  input  logic             charXfer,
  input  logic             fifoRead,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             countAtEnd,
  output tmrStrobes_t      strobes
);

  localparam int NIB_LO = CMD_W - 4;

  ctPhase_t   phase, phaseNext;
  logic       tmoMode, tmoModeNext;
  logic [3:0] cmdNib;

  assign cmdNib = cmdByte[CMD_W-1:NIB_LO];

  always_comb begin
    strobes           = '0;
    strobes.wdRestart = fifoRead;
    strobes.wdAdvance = bitTick;
    phaseNext         = phase;
    tmoModeNext       = tmoMode;

    if (cmdValid && cmdNib == CMD_TMO_ON) begin
      tmoModeNext      = 1'b1;
      phaseNext        = PH_IDLE;
      strobes.clrReady = 1'b1;
    end else if (cmdValid && cmdNib == CMD_TMO_OFF) begin
      tmoModeNext      = 1'b0;
      phaseNext        = PH_IDLE;
      strobes.clrReady = 1'b1;
    end else if (cmdValid && cmdNib == CMD_START && !tmoMode) begin
      strobes.loadCount = 1'b1;
      phaseNext         = PH_RUN;
    end else if (cmdValid && cmdNib == CMD_STOP && !tmoMode) begin
      phaseNext = PH_IDLE;
    end else if (charXfer && tmoMode) begin
      phaseNext = PH_HALT;
    end else if (ctClkEn) begin
      unique case (phase)
        PH_HALT: begin
          strobes.loadCount = 1'b1;
          phaseNext         = PH_ARMED;
        end
        PH_ARMED: phaseNext = PH_RUN;
        PH_RUN: begin
          strobes.decCount = 1'b1;
          if (countAtEnd) begin
            strobes.setReady = 1'b1;
            phaseNext        = PH_IDLE;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tmoMode <= 1'b0;
    end else begin
      phase   <= phaseNext;
      tmoMode <= tmoModeNext;
    end
  end

endmodule

// File: rtl/rx_timer_datapath.sv
module rx_timer_datapath
  import rx_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int WD_LIMIT = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strobes,
  input  logic [CNT_W-1:0] reloadValue,
  output logic             countAtEnd,
  output logic             ctReady,
  output logic             wdFlag
);

  localparam int WD_W = $clog2(WD_LIMIT + 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_LIMIT - 1);

  logic [CNT_W-1:0] count;
  logic [WD_W-1:0]  wdCnt;

  assign countAtEnd = (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.loadCount) begin
      count <= reloadValue;
    end else if (strobes.decCount && count != '0) begin
      count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctReady <= 1'b0;
    end else if (strobes.clrReady) begin
      ctReady <= 1'b0;
    end else if (strobes.setReady) begin
      ctReady <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdCnt  <= '0;
      wdFlag <= 1'b0;
    end else if (strobes.wdRestart) begin
      wdCnt  <= '0;
      wdFlag <= 1'b0;
    end else if (strobes.wdAdvance && !wdFlag) begin
      if (wdCnt == WD_LAST) begin
        wdCnt  <= '0;
        wdFlag <= 1'b1;
      end else begin
        wdCnt <= wdCnt + WD_W'(1);
      end
    end
  end

endmodule

// File: rtl/rx_inactivity_timer.sv
module rx_inactivity_timer
  import rx_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int WD_LIMIT = 64,
  parameter int CMD_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             ctClkEn,
  input  logic             charXfer,
  input  logic             fifoRead,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic [CNT_W-1:0] reloadValue,
  input  logic             wdEnable,
  input  logic             ctMask,
  output logic             wdFlag,
  output logic             wdIrq,
  output logic             ctReady,
  output logic             ctIrq
);

  tmrStrobes_t strobes;
  logic        countAtEnd;

  rx_timer_ctrl #(.CMD_W(CMD_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .ctClkEn   (ctClkEn),
    .charXfer  (charXfer),
    .fifoRead  (fifoRead),
    .cmdValid  (cmdValid),
    .cmdByte   (cmdByte),
    .countAtEnd(countAtEnd),
    .strobes   (strobes)
  );

  rx_timer_datapath #(.CNT_W(CNT_W), .WD_LIMIT(WD_LIMIT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reloadValue(reloadValue),
    .countAtEnd (countAtEnd),
    .ctReady    (ctReady),
    .wdFlag     (wdFlag)
  );

  assign wdIrq = wdFlag & wdEnable;
  assign ctIrq = ctReady & ctMask;

endmodule

// File: rtl/rx_inactivity_timer_checker.sv
module rx_inactivity_timer_checker #(
  parameter int CMD_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitTick,
  input logic             ctClkEn,
  input logic             fifoRead,
  input logic             cmdValid,
  input logic [CMD_W-1:0] cmdByte,
  input logic             wdFlag,
  input logic             ctReady
);

  logic clearCmd;
  assign clearCmd = cmdValid &&
                    (cmdByte[CMD_W-1:CMD_W-4] == 4'hA || cmdByte[CMD_W-1:CMD_W-4] == 4'hC);

  assert_wd_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdFlag) |-> $past(bitTick));

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    fifoRead |=> !wdFlag);

  assert_ready_on_clock_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctReady) |-> $past(ctClkEn));

  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctReady && !clearCmd) |=> ctReady);

  assert_cmd_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    clearCmd |=> !ctReady);

endmodule

bind rx_inactivity_timer rx_inactivity_timer_checker #(.CMD_W(CMD_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .bitTick (bitTick),
  .ctClkEn (ctClkEn),
  .fifoRead(fifoRead),
  .cmdValid(cmdValid),
  .cmdByte (cmdByte),
  .wdFlag  (wdFlag),
  .ctReady (ctReady)
);

// File: tb/rx_inactivity_timer_bench.sv
module rx_inactivity_timer_bench;

  localparam int WDL = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitTick = 0, ctClkEn = 0, charXfer = 0, fifoRead = 0, cmdValid = 0;
  logic [7:0]  cmdByte = '0;
  logic [15:0] reloadValue = '0;
  logic        wdEnable = 0, ctMask = 0;
  logic        wdFlag, wdIrq, ctReady, ctIrq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_inactivity_timer u_rx_inactivity_timer (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .ctClkEn(ctClkEn),
    .charXfer(charXfer), .fifoRead(fifoRead), .cmdValid(cmdValid),
    .cmdByte(cmdByte), .reloadValue(reloadValue), .wdEnable(wdEnable),
    .ctMask(ctMask), .wdFlag(wdFlag), .wdIrq(wdIrq), .ctReady(ctReady),
    .ctIrq(ctIrq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock of stimulus, sampled 1 time unit after the edge
  task automatic step(input logic bt, input logic ce, input logic cx,
                      input logic fr, input logic cv, input logic [7:0] cb);
    bitTick = bt; ctClkEn = ce; charXfer = cx; fifoRead = fr;
    cmdValid = cv; cmdByte = cb;
    @(posedge clk); #1;
    bitTick = 0; ctClkEn = 0; charXfer = 0; fifoRead = 0; cmdValid = 0; cmdByte = '0;
  endtask

  task automatic cmd(input logic [7:0] b);
    step(0, 0, 0, 0, 1, b);
  endtask

  task automatic tick();
    step(0, 1, 0, 0, 0, 8'h00);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rstN = 1'b1;
    // R1
    check("R1 wdFlag", wdFlag, 0);
    check("R1 wdIrq", wdIrq, 0);
    check("R1 ctReady", ctReady, 0);
    check("R1 ctIrq", ctIrq, 0);

    // R2 / R3: watchdog sweep, ticks on alternate cycles in the second pass
    for (int pass = 0; pass < 2; pass++) begin
      step(0, 0, 0, 1, 0, 8'h00);
      check("R3 read clears", wdFlag, 0);
      for (int k = 1; k <= WDL; k++) begin
        step(1, 0, 0, 0, 0, 8'h00);
        check("R2 watchdog count", wdFlag, (k >= WDL));
        if (pass == 1) begin
          idle();
          check("R2 idle holds", wdFlag, (k >= WDL));
        end
      end
    end
    // R4
    wdEnable = 0; #1; check("R4 irq gated off", wdIrq, 0);
    wdEnable = 1; #1; check("R4 irq on", wdIrq, 1);
    // R3 restart mid-count
    step(0, 0, 0, 1, 0, 8'h00);
    check("R3 cleared", wdFlag, 0);
    check("R4 irq follows", wdIrq, 0);
    for (int k = 1; k < WDL; k++) step(1, 0, 0, 0, 0, 8'h00);
    step(1, 0, 0, 1, 0, 8'h00);
    check("R3 read beats tick", wdFlag, 0);
    step(1, 0, 0, 0, 0, 8'h00);
    check("R3 count restarted", wdFlag, 0);
    wdEnable = 0;

    // R5 / R6 / R7: timeout sweep over reload values
    for (int r = 0; r < 8; r++) begin
      int rv, n;
      rv = (r < 6) ? r : (r == 6 ? 17 : 40);
      n = 2 + ((rv < 1) ? 1 : rv);
      reloadValue = 16'(rv);
      cmd(8'hA3);
      check("R8 arm clears", ctReady, 0);
      step(0, 0, 1, 0, 0, 8'h00);
      for (int i = 1; i <= n + 2; i++) begin
        tick();
        check("R5 ready timing", ctReady, (i >= n));
        idle();
        check("R6 no move without enable", ctReady, (i >= n));
      end
      step(0, 1, 1, 0, 0, 8'h00);
      check("R7 sticky after transfer", ctReady, 1);
      ctMask = 0; #1; check("R12 masked", ctIrq, 0);
      ctMask = 1; #1; check("R12 unmasked", ctIrq, 1);
    end

    // R8: armed counter stays stopped until a transfer
    reloadValue = 16'd2;
    cmd(8'hA0);
    check("R8 cleared", ctReady, 0);
    check("R12 follows clear", ctIrq, 0);
    for (int i = 0; i < 10; i++) tick();
    check("R8 held stopped", ctReady, 0);

    // R11: start command ignored in timeout mode
    cmd(8'h80);
    for (int i = 0; i < 6; i++) tick();
    check("R11 start ignored", ctReady, 0);

    // R13: transfer and counter clock together, transfer wins
    step(0, 1, 1, 0, 0, 8'h00);
    for (int i = 1; i <= 4; i++) begin
      tick();
      check("R13 xfer beats clock", ctReady, (i >= 4));
    end
    // R11: stop ignored in timeout mode (re-arm, transfer, stop, still expires)
    cmd(8'hA0);
    step(0, 0, 1, 0, 0, 8'h00);
    cmd(8'h90);
    for (int i = 1; i <= 4; i++) tick();
    check("R11 stop ignored", ctReady, 1);

    // R9: disarm clears and stops
    cmd(8'hC0);
    check("R9 disarm clears", ctReady, 0);
    step(0, 0, 1, 0, 0, 8'h00);
    for (int i = 0; i < 8; i++) tick();
    check("R11 xfer ignored outside mode", ctReady, 0);

    // R10: plain start / stop
    for (int rv = 0; rv < 6; rv++) begin
      int n;
      n = (rv < 1) ? 1 : rv;
      reloadValue = 16'(rv);
      cmd(8'hC0);
      cmd(8'h80);
      for (int i = 1; i <= n + 1; i++) begin
        tick();
        check("R10 start timing", ctReady, (i >= n));
      end
    end
    cmd(8'hC0);
    reloadValue = 16'd4;
    cmd(8'h80);
    tick(); tick();
    cmd(8'h90);
    for (int i = 0; i < 6; i++) tick();
    check("R10 stop halts", ctReady, 0);
    // R11: transfer in plain mode does not reload a running counter
    reloadValue = 16'd3;
    cmd(8'h80);
    tick();
    step(0, 0, 1, 0, 0, 8'h00);
    tick();
    check("R11 not yet", ctReady, 0);
    tick();
    check("R11 xfer no reload", ctReady, 1);

    // R13: command beats transfer in the same cycle
    cmd(8'hC0);
    step(0, 0, 1, 0, 1, 8'hA0);
    for (int i = 0; i < 8; i++) tick();
    check("R13 cmd beats xfer", ctReady, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule